// File: doc/BRIEF.md
# Baseline-Corrected Pulse-Count Field Sequencer

This block turns the pulse train of a charge-balancing voltage integrator into a field-change figure. With no input signal the integrator fires at a steady idle rate (about 5000 pulses per second). A positive input slows the pulses and a negative input speeds them up. A sweep of the field therefore shows up as extra or missing pulses against that idle rate. The idle rate also drifts, so the block measures it on both sides of the sweep.

A run has three counting phases. In the first, the idle rate is measured while the field is held steady, over a baseline span of 2^k timebase ticks. In the second, every pulse is counted while the field moves, and the ticks are counted until software ends the window. In the third, the idle rate is measured again over the same span. The block then predicts how many pulses the idle rate alone would have produced in the window: the mean of the two baseline rates multiplied by the window length, rounded with a shift and no divider. It subtracts that prediction from the window count to get a signed excess. It multiplies the excess by a per-pulse field gain, which is nominally 20 G per pulse for the reference loop. It also reports half of that product, which is the saturation field when the sweep goes from one saturation polarity to the other.

Top module: `fieldsweep_seq`

## Requirements
- R1: After reset, done_o is 0, excess_o, field_o and half_o are 0, and the block is idle.
- R2: run_start_i high while idle begins a run, and base_log2_i and gain_i are captured in that cycle. run_start_i, base_log2_i and gain_i have no effect on a run already in progress.
- R3: The two baseline phases each end on the 2^k-th tick_i cycle counted from the start of the phase, where k is the captured base_log2_i. Rising edges of pulse_i are counted separately for the first baseline, the window and the second baseline, each edge going to the phase active in its cycle.
- R4: The window phase follows the first baseline at once and ends in a cycle with win_stop_i high. Its length W is the number of tick_i cycles in the window, including that final cycle, and it may be 0. win_stop_i outside the window has no effect.
- R5: The predicted window count is floor(((n1 + n2) * W + 2^k) / 2^(k+1)), where n1 and n2 are the baseline counts.
- R6: excess_o is the window pulse count minus the predicted count, in two's complement, and may be negative.
- R7: field_o equals excess_o multiplied by the unsigned captured gain. half_o is field_o divided by two, rounded toward minus infinity.
- R8: done_o is high for exactly one cycle. That cycle comes two cycles after the cycle holding the final tick of the second baseline, and the new results first appear at the outputs in that same cycle.
- R9: excess_o, field_o and half_o hold their values in every cycle without done_o, including all through the next run.
- R10: The three pulse counts and the window tick count saturate at their all-ones value and do not wrap.
- R11: A pulse_i level held high for several cycles counts as one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_start_i | input | 1 | Starts a run when the block is idle |
| win_stop_i | input | 1 | Ends the field-change window |
| tick_i | input | 1 | Timebase strobe, one cycle per tick |
| pulse_i | input | 1 | Integrator output pulse level |
| base_log2_i | input | LOG_W | k: each baseline lasts 2^k ticks |
| gain_i | input | SCALE_W | Field increment per excess pulse, unsigned |
| excess_o | output | EX_W | Signed excess pulse count |
| field_o | output | FW | Signed scaled field change |
| half_o | output | FW | Signed half of field_o (saturation field) |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with CNT_W=8, TICK_W=6, LOG_W=3 and SCALE_W=8. These widths make the 255-pulse and 63-tick saturation points reachable in a few hundred cycles, so the clamped window count and window length can be checked together in one run. LOG_W=3 still allows baseline spans from 1 to 128 ticks. That range covers k=0, where the rounding term is a half pulse, and a window of zero ticks. An 8-bit gain of 255 is enough to exercise the signed product and the rounding of a negative half toward minus infinity.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_BASE1 = 3'd1,
    PH_WIN   = 3'd2,
    PH_BASE2 = 3'd3,
    PH_CALC  = 3'd4
  } phase_e;

  // Counting slots: first baseline, window, second baseline.
  localparam int N_SLOTS = 3;

  function automatic phase_e slot_phase(input int slot);
    case (slot)
      0:       return PH_BASE1;
      1:       return PH_WIN;
      default: return PH_BASE2;
    endcase
  endfunction

endpackage

// File: rtl/fsq_edge.sv
module fsq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic rise_o
);

  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= pulse_i;
  end

  // One count per low-to-high transition of the pulse level (R11).
  assign rise_o = pulse_i & ~level_q;

endmodule

// File: rtl/fsq_satcnt.sv
module fsq_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);

  localparam logic [W-1:0] TOP = '1;

  logic at_top;
  assign at_top = (q_o == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 q_o <= '0;
    else if (clr_i)             q_o <= '0;
    else if (inc_i && !at_top)  q_o <= q_o + 1'b1;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && at_top) |=> (q_o == TOP))
    else $error("counter wrapped past all-ones"); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !inc_i) |=> $stable(q_o))
    else $error("counter moved without increment"); // R3

endmodule

// File: rtl/fsq_ctrl.sv
module fsq_ctrl
  import fsq_pkg::*;
#(
  parameter int LOG_W = 4,
  parameter int BT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic [LOG_W-1:0] log2_i,
  output phase_e           phase_o,
  output logic             clear_o,
  output logic             calc_o,
  output logic [LOG_W-1:0] k_o
);

  phase_e           state_q;
  logic [LOG_W-1:0] k_q;
  logic [BT_W-1:0]  bt_q;

  function automatic logic [BT_W-1:0] span_last(input logic [LOG_W-1:0] k);
    logic [BT_W-1:0] one;
    one = BT_W'(1);
    return (one << k) - one;
  endfunction

  // Named internal events.
  logic in_base, start_evt, base_end_evt, win_end_evt;
  assign in_base      = (state_q == PH_BASE1) || (state_q == PH_BASE2);
  assign start_evt    = (state_q == PH_IDLE) && start_i;
  assign base_end_evt = in_base && tick_i && (bt_q == span_last(k_q));
  assign win_end_evt  = (state_q == PH_WIN) && stop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      k_q     <= '0;
      bt_q    <= '0;
    end else begin
      case (state_q)
        PH_IDLE: begin
          if (start_evt) begin
            state_q <= PH_BASE1;
            k_q     <= log2_i;
            bt_q    <= '0;
          end
        end
        PH_BASE1, PH_BASE2: begin
          if (base_end_evt) begin
            state_q <= (state_q == PH_BASE1) ? PH_WIN : PH_CALC;
            bt_q    <= '0;
          end else if (tick_i) begin
            bt_q <= bt_q + 1'b1;
          end
        end
        PH_WIN: begin
          if (win_end_evt) state_q <= PH_BASE2;
        end
        PH_CALC: state_q <= PH_IDLE;
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = state_q;
  assign clear_o = start_evt;
  assign calc_o  = (state_q == PH_CALC);
  assign k_o     = k_q;

  AST_WIN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_WIN) |=> (state_q == PH_WIN || state_q == PH_BASE2))
    else $error("window left to an illegal phase"); // R4

  AST_WIN_WAITS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_WIN && !stop_i) |=> (state_q == PH_WIN))
    else $error("window closed without stop"); // R4

  AST_K_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PH_IDLE) |=> $stable(k_q))
    else $error("span exponent changed mid-run"); // R2

  AST_BASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    in_base |-> (bt_q <= span_last(k_q)))
    else $error("baseline tick count overran its span"); // R3

  AST_CALC_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_CALC) |=> (state_q == PH_IDLE))
    else $error("compute phase lasted more than one cycle"); // R8

endmodule

// File: rtl/fsq_math.sv
module fsq_math #(
  parameter int CNT_W   = 16,
  parameter int TICK_W  = 16,
  parameter int LOG_W   = 4,
  parameter int SCALE_W = 16,
  parameter int EX_W    = 51,
  parameter int FW      = 68
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     calc_i,
  input  logic [LOG_W-1:0]         k_i,
  input  logic [SCALE_W-1:0]       gain_i,
  input  logic [CNT_W-1:0]         n_base1_i,
  input  logic [CNT_W-1:0]         n_win_i,
  input  logic [CNT_W-1:0]         n_base2_i,
  input  logic [TICK_W-1:0]        w_ticks_i,
  output logic signed [EX_W-1:0]   excess_o,
  output logic signed [FW-1:0]     field_o,
  output logic signed [FW-1:0]     half_o,
  output logic                     done_o
);

  localparam int PW = EX_W - 1;

  // Mean baseline rate times window length, rounded half up, by shift only.
  function automatic logic [PW-1:0] predict(
      input logic [CNT_W-1:0]  a,
      input logic [CNT_W-1:0]  b,
      input logic [TICK_W-1:0] w,
      input logic [LOG_W-1:0]  k);
    logic [PW-1:0] acc;
    acc = (PW'(a) + PW'(b)) * PW'(w);
    acc = acc + (PW'(1) << k);
    return (acc >> k) >> 1;
  endfunction

  function automatic logic signed [EX_W-1:0] excess(
      input logic [CNT_W-1:0] got,
      input logic [PW-1:0]    pred);
    return $signed({1'b0, PW'(got)}) - $signed({1'b0, pred});
  endfunction

  function automatic logic signed [FW-1:0] scaled(
      input logic signed [EX_W-1:0] e,
      input logic [SCALE_W-1:0]     g);
    logic signed [FW-1:0] ee, gg;
    ee = FW'(e);
    gg = FW'($signed({1'b0, g}));
    return ee * gg;
  endfunction

  function automatic logic signed [FW-1:0] halve(input logic signed [FW-1:0] f);
    return f >>> 1;
  endfunction

  logic [SCALE_W-1:0]     gain_q;
  logic [PW-1:0]          pred_w;
  logic signed [EX_W-1:0] ex_w;
  logic signed [FW-1:0]   fld_w, hlf_w;

  assign pred_w = predict(n_base1_i, n_base2_i, w_ticks_i, k_i);
  assign ex_w   = excess(n_win_i, pred_w);
  assign fld_w  = scaled(ex_w, gain_q);
  assign hlf_w  = halve(fld_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q   <= '0;
      excess_o <= '0;
      field_o  <= '0;
      half_o   <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (clr_i) gain_q <= gain_i;
      if (calc_i) begin
        excess_o <= ex_w;
        field_o  <= fld_w;
        half_o   <= hlf_w;
        done_o   <= 1'b1;
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("done held longer than one cycle"); // R8

  AST_DONE_AFTER_CALC: assert property (@(posedge clk) disable iff (!rst_n)
    calc_i |=> done_o)
    else $error("compute phase did not raise done"); // R8

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(excess_o) && $stable(field_o) && $stable(half_o)))
    else $error("results moved without done"); // R9

  AST_HALF_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((half_o < 0) == (field_o < 0)))
    else $error("half result sign differs from field"); // R7

endmodule

// File: rtl/fieldsweep_seq.sv
module fieldsweep_seq
  import fsq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TICK_W  = 16,
  parameter int LOG_W   = 4,
  parameter int SCALE_W = 16,
  localparam int BT_W   = 2 ** LOG_W,
  localparam int PW     = CNT_W + TICK_W + BT_W + 2,
  localparam int EX_W   = PW + 1,
  localparam int FW     = EX_W + SCALE_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run_start_i,
  input  logic                   win_stop_i,
  input  logic                   tick_i,
  input  logic                   pulse_i,
  input  logic [LOG_W-1:0]       base_log2_i,
  input  logic [SCALE_W-1:0]     gain_i,
  output logic signed [EX_W-1:0] excess_o,
  output logic signed [FW-1:0]   field_o,
  output logic signed [FW-1:0]   half_o,
  output logic                   done_o
);

  logic             rise_w;
  phase_e           phase_w;
  logic             clear_w, calc_w;
  logic [LOG_W-1:0] k_w;
  logic [N_SLOTS-1:0] slot_inc;
  logic [CNT_W-1:0]   slot_cnt [N_SLOTS];
  logic             win_tick_inc;
  logic [TICK_W-1:0] win_ticks;

  fsq_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse_i (pulse_i),
    .rise_o  (rise_w)
  );

  fsq_ctrl #(.LOG_W(LOG_W), .BT_W(BT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (run_start_i),
    .stop_i  (win_stop_i),
    .tick_i  (tick_i),
    .log2_i  (base_log2_i),
    .phase_o (phase_w),
    .clear_o (clear_w),
    .calc_o  (calc_w),
    .k_o     (k_w)
  );

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    assign slot_inc[s] = rise_w && (phase_w == slot_phase(s));
    fsq_satcnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clear_w),
      .inc_i (slot_inc[s]),
      .q_o   (slot_cnt[s])
    );
  end

  assign win_tick_inc = tick_i && (phase_w == PH_WIN);

  fsq_satcnt #(.W(TICK_W)) u_wticks (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clear_w),
    .inc_i (win_tick_inc),
    .q_o   (win_ticks)
  );

  fsq_math #(
    .CNT_W(CNT_W), .TICK_W(TICK_W), .LOG_W(LOG_W),
    .SCALE_W(SCALE_W), .EX_W(EX_W), .FW(FW)
  ) u_math (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clear_w),
    .calc_i    (calc_w),
    .k_i       (k_w),
    .gain_i    (gain_i),
    .n_base1_i (slot_cnt[0]),
    .n_win_i   (slot_cnt[1]),
    .n_base2_i (slot_cnt[2]),
    .w_ticks_i (win_ticks),
    .excess_o  (excess_o),
    .field_o   (field_o),
    .half_o    (half_o),
    .done_o    (done_o)
  );

  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_inc))
    else $error("pulse credited to more than one phase"); // R3

  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clear_w |-> (phase_w == PH_IDLE))
    else $error("counters cleared outside idle"); // R2

endmodule

// File: tb/fieldsweep_seq_bench.sv
module fieldsweep_seq_bench;

  localparam int CNT_W   = 8;
  localparam int TICK_W  = 6;
  localparam int LOG_W   = 3;
  localparam int SCALE_W = 8;
  localparam int BT_W    = 2 ** LOG_W;
  localparam int EX_W    = CNT_W + TICK_W + BT_W + 3;
  localparam int FW      = EX_W + SCALE_W + 1;
  localparam longint CNT_MAX  = (64'sd1 << CNT_W) - 1;
  localparam longint TICK_MAX = (64'sd1 << TICK_W) - 1;

  typedef struct packed {
    int k; int n1; int nw; int w; int n2; int gain;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2,  8, 20, 5,  8,  20},
    '{3, 10,  3, 6, 14,   7},
    '{1,  3,  4, 2,  2,   5},
    '{0,  1,  0, 1,  0,   3},
    '{2,  5,  9, 0,  7,   1},
    '{0,  2,  6, 3,  2, 255}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_start_i = 1'b0, win_stop_i = 1'b0, tick_i = 1'b0, pulse_i = 1'b0;
  logic [LOG_W-1:0]   base_log2_i = '0;
  logic [SCALE_W-1:0] gain_i = '0;
  logic signed [EX_W-1:0] excess_o;
  logic signed [FW-1:0]   field_o, half_o;
  logic done_o;

  always #5 clk = ~clk;

  fieldsweep_seq #(
    .CNT_W(CNT_W), .TICK_W(TICK_W), .LOG_W(LOG_W), .SCALE_W(SCALE_W)
  ) u_fieldsweep_seq (
    .clk(clk), .rst_n(rst_n), .run_start_i(run_start_i), .win_stop_i(win_stop_i),
    .tick_i(tick_i), .pulse_i(pulse_i), .base_log2_i(base_log2_i), .gain_i(gain_i),
    .excess_o(excess_o), .field_o(field_o), .half_o(half_o), .done_o(done_o)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;
  longint last_ex = 0;

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulses(input int n, input int hold);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pulse_i = 1'b1;
      for (int h = 1; h < hold; h++) @(negedge clk);
      @(negedge clk); pulse_i = 1'b0;
    end
  endtask

  task automatic ticks(input int n, input bit stop_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1; win_stop_i = stop_last && (i == n - 1);
      @(negedge clk); tick_i = 1'b0; win_stop_i = 1'b0;
    end
  endtask

  task automatic run_case(input int k, input int n1, input int nw, input int w,
                          input int n2, input int gain, input int hold,
                          input bit noise, input string tag);
    longint ws, nws, span, pred, ex, fld, hlf;
    span = 64'sd1 << k;
    ws   = (w > TICK_MAX) ? TICK_MAX : w;
    nws  = (nw > CNT_MAX) ? CNT_MAX : nw;
    pred = ((n1 + n2) * ws + span) / (2 * span);
    ex   = nws - pred;
    fld  = ex * gain;
    hlf  = (fld >= 0) ? fld / 2 : -((-fld + 1) / 2);

    @(negedge clk); base_log2_i = k[LOG_W-1:0]; gain_i = gain[SCALE_W-1:0]; run_start_i = 1'b1;
    @(negedge clk); run_start_i = 1'b0;
    if (noise) begin
      // R2: restart, new span and new gain mid-run; R4: stop outside window.
      base_log2_i = '0; gain_i = ~gain[SCALE_W-1:0]; run_start_i = 1'b1; win_stop_i = 1'b1;
      @(negedge clk); run_start_i = 1'b0; win_stop_i = 1'b0;
    end
    pulses(n1, hold);
    ticks(int'(span), 1'b0);
    check({tag, " R9 hold during run"}, longint'(excess_o), last_ex);
    pulses(nw, hold);
    if (w > 0) ticks(w, 1'b1);
    else begin
      @(negedge clk); win_stop_i = 1'b1;
      @(negedge clk); win_stop_i = 1'b0;
    end
    pulses(n2, hold);
    ticks(int'(span), 1'b0);
    check({tag, " R8 done low in compute cycle"}, longint'(done_o), 0);
    @(negedge clk);
    check({tag, " R8 done strobe"}, longint'(done_o), 1);
    check({tag, " R5 R6 excess"}, longint'(excess_o), ex);
    check({tag, " R7 field"}, longint'(field_o), fld);
    check({tag, " R7 half"}, longint'(half_o), hlf);
    @(negedge clk);
    check({tag, " R8 done single cycle"}, longint'(done_o), 0);
    last_ex = ex;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", longint'(done_o), 0);
    check("R1 excess after reset", longint'(excess_o), 0);
    check("R1 field after reset", longint'(field_o), 0);
    check("R1 half after reset", longint'(half_o), 0);

    for (int v = 0; v < NV; v++)
      run_case(VECS[v].k, VECS[v].n1, VECS[v].nw, VECS[v].w, VECS[v].n2,
               VECS[v].gain, 1, 1'b0, $sformatf("vec%0d R3 R4", v));

    repeat (5) @(negedge clk);
    check("R9 hold while idle", longint'(excess_o), last_ex);

    run_case(2, 8, 20, 5, 8, 20, 1, 1'b1, "R2 R4 ignored controls");
    run_case(1, 3, 4, 2, 2, 5, 3, 1'b0, "R11 held pulses");
    run_case(0, 1, 300, 70, 1, 1, 1, 1'b0, "R10 saturation");

    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog R8: actual timeout expected completion");
    finish_up();
  end

endmodule